// File: doc/BRIEF.md
# Interrupt Status and Acknowledge Reply Unit

This block keeps the pending-event status byte and the enable mask of a power-management controller. It drives an active-low interrupt line whenever an enabled event is pending. A host-side command engine pulses `ack_i` to acknowledge interrupts, and the block then streams the acknowledge reply out one byte per cycle.

Three event sources set status bits. A once-per-second tick strobe sets one bit. An explicit peripheral-bus command completion queues a framed reply and sets the peripheral bit. An autopoll delivery queues raw data and sets both the peripheral and autopoll bits, but only when no earlier peripheral reply is still waiting. Peripheral data bytes come from a built-in stub. It derives each byte from a seed and a length, so the bus protocol itself stays outside this block.

When a peripheral reply is queued, the acknowledge reply is a header holding only the peripheral and autopoll bits, followed by the queued bytes. Otherwise the reply is the whole status byte.

Top module: `pmu_irq_ack`

## Requirements
- R1: Status bit positions are fixed: bit 0 is tick, bit 1 is peripheral reply, bit 2 is autopoll. `irq_no_o` is low exactly when the registered status ANDed with the registered mask is nonzero.
- R2: After reset the status is 0x00, the mask is 0x03 (peripheral and tick enabled) and no reply is being sent.
- R3: A pulse on `mask_we_i` loads `mask_i` into the mask. The interrupt line reflects the new mask from the next cycle on.
- R4: A pulse on `tick_i` sets status bit 0.
- R5: A pulse on `cmd_i` with length L and seed S sets status bit 1 and replaces the queue with 0x01, L, then data bytes. Data byte k is (S+k) mod 256. When L is 0, the queue holds the single byte 0x00 instead.
- R6: A pulse on `poll_i` with a nonzero length is accepted only when status bit 1 is clear and `cmd_i` is not pulsed in the same cycle. When accepted, it replaces the queue with the data bytes (S+k) mod 256 and sets status bits 1 and 2. When not accepted, it changes neither the queue nor the status.
- R7: An accepted acknowledge with bit 1 set replies with a header byte equal to status AND 0x06, followed by the queued bytes. It then clears bits 1 and 2, keeps the other bits and empties the queue.
- R8: An accepted acknowledge with bit 1 clear replies with the single full status byte and clears all status bits. An event strobe in the same cycle still sets its bit.
- R9: The queue holds at most 16 bytes. A longer reply is truncated to its first 16 bytes.
- R10: Reply bytes appear on consecutive cycles, starting the cycle after the acknowledge. `rsp_last_o` marks the final byte. An acknowledge that arrives while a reply is being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick event strobe |
| cmd_i | input | 1 | Explicit peripheral command completed |
| cmd_len_i | input | 8 | Data length of the command reply |
| cmd_seed_i | input | 8 | Stub seed for the command reply data |
| poll_i | input | 1 | Autopoll data available |
| poll_len_i | input | 8 | Autopoll data length |
| poll_seed_i | input | 8 | Stub seed for the autopoll data |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | 8 | New mask value |
| ack_i | input | 1 | Interrupt-acknowledge command strobe |
| irq_no_o | output | 1 | Interrupt line, active low |
| rsp_valid_o | output | 1 | Reply byte valid |
| rsp_data_o | output | 8 | Reply byte |
| rsp_last_o | output | 1 | Final reply byte |

## Verification
The assertions check on every cycle the rules that follow a single strobe:
- clearing the mask releases the line;
- tick and command strobes set their bits;
- a blocked autopoll leaves the queue alone;
- a packet acknowledge empties the queue;
- a reply starts right after an idle acknowledge and ends after its last byte.

Only the bench's scenarios show the exact reply byte sequences. These cover the framed command reply, the empty-command marker, the autopoll header with both bits set, truncation at 16 bytes, a tick that survives a packet acknowledge, an event colliding with a status acknowledge, and an acknowledge dropped mid-reply.

// File: rtl/pmu_irq_pkg.sv
package pmu_irq_pkg;
  localparam int STAT_W     = 8;
  localparam int TICK_BIT   = 0;
  localparam int PERIPH_BIT = 1;
  localparam int AUTO_BIT   = 2;
  localparam logic [STAT_W-1:0] MASK_RST  = 8'h03;
  localparam logic [STAT_W-1:0] PKT_BITS  = 8'h06;
  localparam logic [7:0]        HDR_DATA  = 8'h01;
  localparam logic [7:0]        HDR_EMPTY = 8'h00;
endpackage

// File: rtl/pmu_periph_stub.sv
module pmu_periph_stub #(
  parameter int DEPTH = 16
) (
  input  logic [7:0]         seed_i,
  output logic [DEPTH*8-1:0] bytes_o
);
  // byte k = seed + k
  for (genvar k = 0; k < DEPTH; k++) begin : g_byte
    assign bytes_o[k*8 +: 8] = seed_i + 8'(k);
  end
endmodule

// File: rtl/pmu_irq_status.sv
module pmu_irq_status
  import pmu_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_set_i,
  input  logic              cmd_set_i,
  input  logic              poll_set_i,
  input  logic              clr_all_i,
  input  logic              clr_pkt_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_no_o
);
  logic [STAT_W-1:0] status_q, status_d, mask_q;

  always_comb begin
    status_d = status_q;
    if (clr_all_i) status_d = '0;
    if (clr_pkt_i) status_d = status_d & ~PKT_BITS;
    // events win over any clear in the same cycle
    if (tick_set_i) status_d[TICK_BIT] = 1'b1;
    if (cmd_set_i)  status_d[PERIPH_BIT] = 1'b1;
    if (poll_set_i) begin
      status_d[PERIPH_BIT] = 1'b1;
      status_d[AUTO_BIT]   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= MASK_RST;
    end else begin
      status_q <= status_d;
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign status_o = status_q;
  assign irq_no_o = ~|(status_q & mask_q);
endmodule

// File: rtl/pmu_reply_queue.sv
module pmu_reply_queue
  import pmu_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               cmd_load_i,
  input  logic [7:0]         cmd_len_i,
  input  logic [7:0]         cmd_seed_i,
  input  logic               poll_load_i,
  input  logic [7:0]         poll_len_i,
  input  logic [7:0]         poll_seed_i,
  output logic [DEPTH*8-1:0] q_bytes_o,
  output logic [CNT_W-1:0]   q_cnt_o
);
  logic [DEPTH*8-1:0] cmd_data, poll_data, cmd_img, q_mem;
  logic [CNT_W-1:0]   cmd_cnt, poll_cnt, q_cnt;

  pmu_periph_stub #(.DEPTH(DEPTH)) u_cmd_stub  (.seed_i(cmd_seed_i),  .bytes_o(cmd_data));
  pmu_periph_stub #(.DEPTH(DEPTH)) u_poll_stub (.seed_i(poll_seed_i), .bytes_o(poll_data));

  // framed image: marker, length, data
  for (genvar k = 0; k < DEPTH; k++) begin : g_img
    if (k == 0) begin : g_hdr
      assign cmd_img[7:0] = (cmd_len_i == 8'd0) ? HDR_EMPTY : HDR_DATA;
    end else if (k == 1) begin : g_len
      assign cmd_img[15:8] = cmd_len_i;
    end else begin : g_dat
      assign cmd_img[k*8 +: 8] = cmd_data[(k-2)*8 +: 8];
    end
  end

  always_comb begin
    logic [8:0] framed;
    framed = {1'b0, cmd_len_i} + 9'd2;
    if (cmd_len_i == 8'd0)           cmd_cnt = CNT_W'(1);
    else if (framed > 9'(DEPTH))     cmd_cnt = CNT_W'(DEPTH);
    else                             cmd_cnt = CNT_W'(framed);
    if ({1'b0, poll_len_i} > 9'(DEPTH)) poll_cnt = CNT_W'(DEPTH);
    else                                poll_cnt = CNT_W'(poll_len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_mem <= '0;
      q_cnt <= '0;
    end else if (cmd_load_i) begin
      q_mem <= cmd_img;
      q_cnt <= cmd_cnt;
    end else if (poll_load_i) begin
      q_mem <= poll_data;
      q_cnt <= poll_cnt;
    end else if (clr_i) begin
      q_cnt <= '0;
    end
  end

  assign q_bytes_o = q_mem;
  assign q_cnt_o   = q_cnt;
endmodule

// File: rtl/pmu_ack_tx.sv
module pmu_ack_tx #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int REM_W = $clog2(DEPTH + 2),
  localparam int BUF_N = DEPTH + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [7:0]         hdr_i,
  input  logic [DEPTH*8-1:0] body_i,
  input  logic [CNT_W-1:0]   body_cnt_i,
  output logic               valid_o,
  output logic [7:0]         data_o,
  output logic               last_o
);
  logic [BUF_N*8-1:0] buf_q;
  logic [REM_W-1:0]   rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      rem_q <= '0;
    end else if (go_i) begin
      buf_q <= {body_i, hdr_i};
      rem_q <= REM_W'(body_cnt_i) + REM_W'(1);
    end else if (rem_q != '0) begin
      buf_q <= {8'h00, buf_q[BUF_N*8-1:8]};
      rem_q <= rem_q - REM_W'(1);
    end
  end

  assign valid_o = (rem_q != '0);
  assign last_o  = (rem_q == REM_W'(1));
  assign data_o  = buf_q[7:0];
endmodule

// File: rtl/pmu_irq_ack.sv
module pmu_irq_ack
  import pmu_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cmd_i,
  input  logic [7:0] cmd_len_i,
  input  logic [7:0] cmd_seed_i,
  input  logic       poll_i,
  input  logic [7:0] poll_len_i,
  input  logic [7:0] poll_seed_i,
  input  logic       mask_we_i,
  input  logic [7:0] mask_i,
  input  logic       ack_i,
  output logic       irq_no_o,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       rsp_last_o
);
  logic [STAT_W-1:0]  status;
  logic [DEPTH*8-1:0] q_bytes;
  logic [CNT_W-1:0]   q_cnt;
  logic ack_go, pkt_pending, poll_take;

  assign pkt_pending = status[PERIPH_BIT];
  assign ack_go      = ack_i & ~rsp_valid_o;
  assign poll_take   = poll_i & ~pkt_pending & ~cmd_i & (poll_len_i != 8'd0);

  pmu_irq_status u_status (
    .clk_i, .rst_ni,
    .tick_set_i (tick_i),
    .cmd_set_i  (cmd_i),
    .poll_set_i (poll_take),
    .clr_all_i  (ack_go & ~pkt_pending),
    .clr_pkt_i  (ack_go & pkt_pending),
    .mask_we_i,
    .mask_i,
    .status_o   (status),
    .irq_no_o
  );

  pmu_reply_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .clr_i       (ack_go & pkt_pending),
    .cmd_load_i  (cmd_i),
    .cmd_len_i, .cmd_seed_i,
    .poll_load_i (poll_take),
    .poll_len_i, .poll_seed_i,
    .q_bytes_o   (q_bytes),
    .q_cnt_o     (q_cnt)
  );

  pmu_ack_tx #(.DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni,
    .go_i       (ack_go),
    .hdr_i      (pkt_pending ? (status & PKT_BITS) : status),
    .body_i     (q_bytes),
    .body_cnt_i (pkt_pending ? q_cnt : '0),
    .valid_o    (rsp_valid_o),
    .data_o     (rsp_data_o),
    .last_o     (rsp_last_o)
  );
endmodule

// File: rtl/pmu_irq_ack_chk.sv
module pmu_irq_ack_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             cmd_i,
  input logic             poll_i,
  input logic             mask_we_i,
  input logic [7:0]       mask_i,
  input logic             ack_i,
  input logic             irq_no_o,
  input logic             rsp_valid_o,
  input logic             rsp_last_o,
  input logic [7:0]       status,
  input logic [CNT_W-1:0] q_cnt
);
  assert_mask_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i && mask_i == 8'h00 |=> irq_no_o);
  assert_tick_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> status[0]);
  assert_cmd_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> status[1]);
  assert_poll_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i && status[1] && !cmd_i && !ack_i |=> $stable(q_cnt) && status[1]);
  assert_pkt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !rsp_valid_o && status[1] && !cmd_i |=> !status[1] && !status[2] && q_cnt == '0);
  assert_queue_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt <= CNT_W'(DEPTH));
  assert_ack_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !rsp_valid_o |=> rsp_valid_o);
  assert_last_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |=> !rsp_valid_o);
endmodule

bind pmu_irq_ack pmu_irq_ack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .tick_i, .cmd_i, .poll_i, .mask_we_i, .mask_i, .ack_i,
  .irq_no_o, .rsp_valid_o, .rsp_last_o,
  .status (status),
  .q_cnt  (q_cnt)
);

// File: tb/pmu_irq_ack_bench.sv
module pmu_irq_ack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk_i = 0, rst_ni = 0;
  logic tick_i = 0, cmd_i = 0, poll_i = 0, mask_we_i = 0, ack_i = 0;
  logic [7:0] cmd_len_i = 0, cmd_seed_i = 0, poll_len_i = 0, poll_seed_i = 0, mask_i = 0;
  logic irq_no_o, rsp_valid_o, rsp_last_o;
  logic [7:0] rsp_data_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_b [0:DEPTH];
  int exp_n;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pmu_irq_ack #(.DEPTH(DEPTH)) u_pmu_irq_ack (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_cmd(int len, int seed);
    exp_b[0] = 8'h02;
    if (len == 0) begin exp_b[1] = 8'h00; exp_n = 2; end
    else begin
      exp_b[1] = 8'h01; exp_b[2] = 8'(len);
      exp_n = (len + 2 > DEPTH) ? DEPTH + 1 : len + 3;
      for (int k = 3; k < exp_n; k++) exp_b[k] = 8'(seed + k - 3);
    end
  endtask

  task automatic exp_one(int b);
    exp_b[0] = 8'(b); exp_n = 1;
  endtask

  task automatic pulse_tick();
    @(negedge clk_i) tick_i = 1; @(negedge clk_i) tick_i = 0;
  endtask

  task automatic pulse_cmd(int len, int seed);
    @(negedge clk_i) begin cmd_i = 1; cmd_len_i = 8'(len); cmd_seed_i = 8'(seed); end
    @(negedge clk_i) cmd_i = 0;
  endtask

  task automatic pulse_poll(int len, int seed);
    @(negedge clk_i) begin poll_i = 1; poll_len_i = 8'(len); poll_seed_i = 8'(seed); end
    @(negedge clk_i) poll_i = 0;
  endtask

  task automatic write_mask(int m);
    @(negedge clk_i) begin mask_we_i = 1; mask_i = 8'(m); end
    @(negedge clk_i) mask_we_i = 0;
  endtask

  // acknowledge and compare the reply stream against exp_b
  task automatic run_ack(string req, int poke, bit with_tick);
    @(negedge clk_i) begin ack_i = 1; tick_i = with_tick; end
    @(negedge clk_i) begin ack_i = 0; tick_i = 0; end
    for (int i = 0; i < exp_n; i++) begin
      chk({req, " valid"}, int'(rsp_valid_o), 1);
      chk({req, " data"}, int'(rsp_data_o), int'(exp_b[i]));
      chk({req, " last"}, int'(rsp_last_o), int'(i == exp_n - 1));
      ack_i = (i == poke);
      @(negedge clk_i);
      ack_i = 0;
    end
    chk({req, " end"}, int'(rsp_valid_o), 0);
  endtask

  task automatic t_reset();
    chk("R2 irq", int'(irq_no_o), 1);
    chk("R2 valid", int'(rsp_valid_o), 0);
    exp_one(8'h00); run_ack("R2 status", -1, 0);
  endtask

  task automatic t_tick();
    pulse_tick();
    chk("R4 R1 irq", int'(irq_no_o), 0);
    exp_one(8'h01); run_ack("R8 tick", -1, 0);
    chk("R8 cleared", int'(irq_no_o), 1);
  endtask

  task automatic t_mask();
    write_mask(8'h00);
    pulse_tick();
    chk("R3 masked", int'(irq_no_o), 1);
    write_mask(8'h01);
    chk("R3 unmasked", int'(irq_no_o), 0);
    exp_one(8'h01); run_ack("R3 ack", -1, 0);
    write_mask(8'h03);
  endtask

  task automatic t_cmd();
    pulse_cmd(3, 8'h40);
    chk("R5 irq", int'(irq_no_o), 0);
    exp_cmd(3, 8'h40); run_ack("R5 R7 cmd", -1, 0);
    chk("R7 irq", int'(irq_no_o), 1);
    pulse_cmd(0, 8'h55);
    exp_cmd(0, 0); run_ack("R5 empty", -1, 0);
  endtask

  task automatic t_poll();
    pulse_poll(0, 8'h70);
    exp_one(8'h00); run_ack("R6 zero len", -1, 0);
    pulse_poll(2, 8'h80);
    chk("R6 irq", int'(irq_no_o), 0);
    exp_b[0] = 8'h06; exp_b[1] = 8'h80; exp_b[2] = 8'h81; exp_n = 3;
    run_ack("R6 R7 poll", -1, 0);
  endtask

  task automatic t_suppress();
    pulse_cmd(1, 8'h10);
    pulse_poll(2, 8'h90);
    exp_cmd(1, 8'h10); run_ack("R6 blocked", -1, 0);
    exp_one(8'h00); run_ack("R6 no bits", -1, 0);
  endtask

  task automatic t_trunc();
    pulse_cmd(20, 8'h00);
    exp_cmd(20, 8'h00); run_ack("R9 trunc", -1, 0);
  endtask

  task automatic t_keep_tick();
    pulse_tick();
    pulse_cmd(1, 8'h20);
    exp_cmd(1, 8'h20); run_ack("R7 header", -1, 0);
    chk("R7 tick kept", int'(irq_no_o), 0);
    exp_one(8'h01); run_ack("R7 tick ack", -1, 0);
    chk("R7 idle", int'(irq_no_o), 1);
  endtask

  task automatic t_same_cycle();
    pulse_tick();
    exp_one(8'h01); run_ack("R8 collide", -1, 1);
    chk("R8 event wins", int'(irq_no_o), 0);
    exp_one(8'h01); run_ack("R8 after", -1, 0);
  endtask

  task automatic t_busy();
    pulse_cmd(2, 8'h30);
    exp_cmd(2, 8'h30); run_ack("R10 busy", 1, 0);
    chk("R10 no restart", int'(rsp_valid_o), 0);
    exp_one(8'h00); run_ack("R10 next", -1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_tick();
    t_mask();
    t_cmd();
    t_poll();
    t_suppress();
    t_trunc();
    t_keep_tick();
    t_same_cycle();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule